// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulate Unit

This unit performs the integer dot-product-and-accumulate operation of a 128-bit vector datapath. It receives a 32-bit instruction word along with three operand vectors that were fetched elsewhere: the current accumulator, the first source and the second source. For each 32-bit lane it multiplies the four byte pairs at that lane's position, adds the four products to the lane's previous accumulator value, and returns the whole accumulator vector.

Two instruction bits choose between signed and unsigned bytes and between a 64-bit and a 128-bit vector. A second encoding group, the indexed form, takes one 32-bit group of the second source and uses it for every lane. The result is registered and appears one cycle after `in_valid`, together with `out_valid`. An encoding that matches neither form raises `illegal` and returns the accumulator unchanged.

Top module: `byte_dot_acc`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` and `illegal` are 0.
- R2: `out_valid` is 1 exactly in the cycle after a cycle in which `in_valid` was 1, and is 0 at all other times.
- R3: Vector form: the instruction matches when bit 31=0, bits 28:24=01110, bits 23:22=10, bit 21=0, bits 15:11=0x12 and bit 10=1. Lane i of the result (bits 32i+31:32i) is the lane of `acc_in` plus the sum, over j=0..3, of byte j of `src_a` lane i times byte j of `src_b` lane i. Byte j is bits 8j+7:8j of the lane.
- R4: When bit 29 is 0, the bytes are sign-extended before they are multiplied.
- R5: When bit 29 is 1, the bytes are zero-extended before they are multiplied.
- R6: When bit 30 is 0, only lanes 0 and 1 are computed and result bits 127:64 are 0. When bit 30 is 1, all four lanes are computed.
- R7: Indexed form: the instruction matches when bit 31=0, bits 28:24=01111, bits 23:22=10, bits 15:12=0xE and bit 10=0. The group index is {bit 11, bit 21}, and that 32-bit group of `src_b` is used as the second operand of every lane. Bits 29 and 30 act as in R4, R5 and R6.
- R8: Accumulation wraps modulo 2^32 with no saturation.
- R9: A valid instruction that matches neither form gives `illegal`=1 with `out_valid`, and `result` equals the `acc_in` given with that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation issued this cycle |
| instr | input | 32 | Instruction word |
| acc_in | input | 128 | Accumulator vector (read) |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| out_valid | output | 1 | Result available |
| result | output | 128 | Updated accumulator vector |
| illegal | output | 1 | Encoding matched neither form |

## Verification
When operations are issued back to back, the result of one instruction is presented in the same cycle in which the next one is accepted. Legal and illegal encodings can also follow one another directly, so a flagged pass-through and a computed result occupy neighbouring cycles. The bench provokes both by issuing long unbroken streams that mix all four variants, both forms and corrupted encodings, and by inserting idle gaps at random. On every clock it compares `out_valid`, `illegal` and the full result against a behavioural model that it advances one cycle at a time.

// File: rtl/byte_dot_acc.sv
module byte_dot_acc #(
  parameter int LANES = 4,
  parameter int BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [31:0]              instr,
  input  logic [LANES*BYTES*8-1:0] acc_in,
  input  logic [LANES*BYTES*8-1:0] src_a,
  input  logic [LANES*BYTES*8-1:0] src_b,
  output logic                     out_valid,
  output logic [LANES*BYTES*8-1:0] result,
  output logic                     illegal
);
  localparam int LW   = BYTES * 8;
  localparam int VW   = LANES * LW;
  localparam int PW   = 18;
  localparam int HALF = LANES / 2;

  logic       vec_hit, idx_hit, legal, sgn, wide;
  logic [1:0] grp;
  logic [LW-1:0] bcast;
  logic [VW-1:0] next_res;

  assign vec_hit = ~instr[31] && instr[28:24] == 5'b01110 && instr[23:22] == 2'b10
                 && ~instr[21] && instr[15:11] == 5'h12 && instr[10];
  assign idx_hit = ~instr[31] && instr[28:24] == 5'b01111 && instr[23:22] == 2'b10
                 && instr[15:12] == 4'hE && ~instr[10];
  assign legal = vec_hit || idx_hit;
  assign sgn   = ~instr[29];
  assign wide  = instr[30];
  assign grp   = {instr[11], instr[21]};
  assign bcast = src_b[grp*LW +: LW];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LW-1:0] bw, sum;
    assign bw = idx_hit ? bcast : src_b[i*LW +: LW];
    always_comb begin
      logic signed [8:0]    ea, eb;
      logic signed [PW-1:0] p;
      sum = acc_in[i*LW +: LW];
      for (int j = 0; j < BYTES; j++) begin
        ea  = {sgn & src_a[i*LW + 8*j + 7], src_a[i*LW + 8*j +: 8]};
        eb  = {sgn & bw[8*j + 7], bw[8*j +: 8]};
        p   = PW'(ea * eb);
        sum = sum + {{(LW-PW){p[PW-1]}}, p};
      end
    end
    if (i < HALF) begin : g_low
      assign next_res[i*LW +: LW] = sum;
    end else begin : g_high
      assign next_res[i*LW +: LW] = wide ? sum : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid && !legal;
      if (in_valid) result <= legal ? next_res : acc_in;
    end
  end
endmodule

// File: rtl/byte_dot_acc_chk.sv
module byte_dot_acc_chk #(
  parameter int VW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [31:0]   instr,
  input logic [VW-1:0] acc_in,
  input logic          out_valid,
  input logic          illegal,
  input logic [VW-1:0] result
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  // R9
  illegal_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> out_valid);
  // R9
  illegal_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> result == $past(acc_in));
  // R6
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !illegal && !$past(instr[30])) |-> result[VW-1:VW/2] == '0);
endmodule

bind byte_dot_acc byte_dot_acc_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
  .acc_in(acc_in), .out_valid(out_valid), .illegal(illegal), .result(result)
);

// File: tb/test_byte_dot_acc.sv
`timescale 1ns/1ps
module test_byte_dot_acc;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [31:0] instr = '0;
  logic [127:0] acc_in = '0, src_a = '0, src_b = '0;
  logic out_valid, illegal;
  logic [127:0] result;
  int total = 0, bad = 0;
  bit done = 0;

  logic exp_v = 0, exp_ill = 0;
  logic [127:0] exp_res = '0;
  string exp_tag = "R2";

  byte_dot_acc i_byte_dot_acc (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .instr(instr), .acc_in(acc_in), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .result(result), .illegal(illegal));

  always #2.5 clk = ~clk;

  function automatic logic [31:0] vec_ins(bit q, bit u);
    return {1'b0, q, u, 5'b01110, 2'b10, 1'b0, 5'd3, 5'h12, 1'b1, 5'd1, 5'd2};
  endfunction
  function automatic logic [31:0] idx_ins(bit q, bit u, logic [1:0] ix);
    return {1'b0, q, u, 5'b01111, 2'b10, ix[0], 1'b0, 4'd5, 4'hE, ix[1], 1'b0, 5'd1, 5'd2};
  endfunction

  task automatic model(input logic [31:0] ins, input logic [127:0] acc, a, b,
                       output logic ill, output logic [127:0] res, output string tag);
    bit isv, isx;
    int lanes, g;
    isv = ins[31] == 0 && ins[28:24] == 5'b01110 && ins[23:22] == 2 && ins[21] == 0
          && ins[15:11] == 5'h12 && ins[10] == 1;
    isx = ins[31] == 0 && ins[28:24] == 5'b01111 && ins[23:22] == 2
          && ins[15:12] == 4'hE && ins[10] == 0;
    ill = !(isv || isx);
    res = '0;
    if (ill) begin res = acc; tag = "R9"; return; end
    tag = isx ? "R7" : (ins[29] ? "R5" : "R4");
    lanes = ins[30] ? 4 : 2;
    g = ins[11] * 2 + ins[21];
    for (int i = 0; i < lanes; i++) begin
      int s;
      s = int'(acc[32*i +: 32]);
      for (int j = 0; j < 4; j++) begin
        int x, y;
        logic [7:0] ab, bb;
        ab = a[32*i + 8*j +: 8];
        bb = isx ? b[32*g + 8*j +: 8] : b[32*i + 8*j +: 8];
        x = ins[29] ? int'(ab) : int'($signed(ab));
        y = ins[29] ? int'(bb) : int'($signed(bb));
        s = s + x * y;
      end
      res[32*i +: 32] = s;
    end
  endtask

  task automatic chk(input string tag, input logic [127:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] ins, input logic [127:0] acc, a, b);
    @(negedge clk);
    chk("R2", {127'd0, out_valid}, {127'd0, exp_v});
    if (exp_v) begin
      chk(exp_tag, {127'd0, illegal}, {127'd0, exp_ill});
      chk(exp_tag, result, exp_res);
    end else chk("R2", {127'd0, illegal}, 128'd0);
    in_valid = v; instr = ins; acc_in = acc; src_a = a; src_b = b;
    exp_v = v;
    if (v) model(ins, acc, a, b, exp_ill, exp_res, exp_tag);
  endtask

  function automatic logic [127:0] r128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {126'd0, out_valid, illegal}, 128'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {126'd0, out_valid, illegal}, 128'd0);

    // R3 directed: bytes 1..4 times 5..8 -> 70 in every lane
    step(1, vec_ins(1, 1), '0, {4{32'h04030201}}, {4{32'h08070605}});
    step(0, '0, '0, '0, '0);
    chk("R3", result, {4{32'd70}});
    // R4 signed: -1 * 2 four times -> -8
    step(1, vec_ins(1, 0), '0, {4{32'hFFFFFFFF}}, {4{32'h02020202}});
    step(0, '0, '0, '0, '0);
    chk("R4", result, {4{32'hFFFFFFF8}});
    // R5 unsigned: 255 * 2 four times -> 2040
    step(1, vec_ins(1, 1), '0, {4{32'hFFFFFFFF}}, {4{32'h02020202}});
    step(0, '0, '0, '0, '0);
    chk("R5", result, {4{32'd2040}});
    // R6 narrow form clears the upper half
    step(1, vec_ins(0, 1), {128{1'b1}}, '0, '0);
    step(0, '0, '0, '0, '0);
    chk("R6", result, {64'd0, {64{1'b1}}});
    // R8 wrap
    step(1, vec_ins(1, 1), {4{32'hFFFFFFFF}}, {4{32'h01010101}}, {4{32'h01010101}});
    step(0, '0, '0, '0, '0);
    chk("R8", result, {4{32'd3}});
    // R7 group 2 broadcast
    step(1, idx_ins(1, 1, 2'd2), '0, {4{32'h01010101}}, {32'd0, 32'h03030303, 64'd0});
    step(0, '0, '0, '0, '0);
    chk("R7", result, {4{32'd12}});
    // R9 corrupted size field
    step(1, vec_ins(1, 0) ^ 32'h0040_0000, 128'h1234, r128(), r128());
    step(0, '0, '0, '0, '0);
    chk("R9", {127'd0, illegal}, 128'd1);
    chk("R9", result, 128'h1234);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ins;
      int k;
      k = $urandom_range(0, 9);
      if (k < 4) ins = vec_ins($urandom_range(0, 1), $urandom_range(0, 1));
      else if (k < 8) ins = idx_ins($urandom_range(0, 1), $urandom_range(0, 1), 2'($urandom_range(0, 3)));
      else if (k == 8) ins = vec_ins(1, 0) ^ (32'd1 << $urandom_range(0, 31));
      else ins = $urandom;
      step($urandom_range(0, 5) != 0, ins, r128(), r128(), r128());
    end
    step(0, '0, '0, '0, '0);
    step(0, '0, '0, '0, '0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule